// File: doc/BRIEF.md
# Dual-Synthesizer Serial Programming Port

This block receives 24-bit configuration words for a two-channel frequency synthesizer over three wires: a serial clock, a serial data line and a load strobe. Bits enter a shift register most significant bit first, one per rising edge of the serial clock. The low two bits of each word are a routing code. On a rising edge of the load strobe, the word held in the shift register is copied into one of four holding registers. Each channel has a reference-divider register and a feedback-divider register. The feedback-divider register holds a 6-bit A count and a 12-bit B count.

The three serial wires are asynchronous to the chip. They pass through a synchronizer into the system clock domain, and an edge detector finds their rising edges there. This keeps all state on one clock with a synchronous active-low reset. The serial clock must stay in each level for several system clocks. Bits 23:2 of a routed word are a 22-bit payload. In a reference word this payload splits into a 14-bit count and an 8-bit auxiliary field. In a feedback word it splits into an A count, a B count and a 4-bit auxiliary field. The holding registers drive parallel outputs. These outputs change only when a word is loaded or on reset.

Top module: `pll_ser_load`

## Requirements
- R1: While `rst_n` is sampled low, the shift register and all four holding registers clear to zero, so every output reads 0.
- R2: Serial data is taken most significant bit first. Only the last 24 bits shifted before a load form the word, and earlier bits are pushed out.
- R3: Routing code 2'b00 (word bits 1:0) loads channel 2's reference register: count = word[15:2], auxiliary = word[23:16].
- R4: Routing code 2'b01 loads channel 2's feedback register: A = word[7:2], B = word[19:8], auxiliary = word[23:20].
- R5: Routing code 2'b10 loads channel 1's reference register, using the same field positions as R3.
- R6: Routing code 2'b11 loads channel 1's feedback register, using the same field positions as R4.
- R7: A load changes only the register chosen by its routing code. The other three keep their values.
- R8: Shifting never changes a holding register. Holding the load strobe high while shifting is allowed and loads nothing further until the next rising edge of the strobe.
- R9: Data is sampled only at rising edges of the serial clock. Changes on the data line while the serial clock holds its level have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first (asynchronous) |
| ser_load_i | input | 1 | Load strobe, rising edge transfers the word (asynchronous) |
| ch1_ref_cnt_o | output | 14 | Channel 1 reference count |
| ch1_ref_aux_o | output | 8 | Channel 1 reference auxiliary field |
| ch1_a_cnt_o | output | 6 | Channel 1 feedback A count |
| ch1_b_cnt_o | output | 12 | Channel 1 feedback B count |
| ch1_fb_aux_o | output | 4 | Channel 1 feedback auxiliary field |
| ch2_ref_cnt_o | output | 14 | Channel 2 reference count |
| ch2_ref_aux_o | output | 8 | Channel 2 reference auxiliary field |
| ch2_a_cnt_o | output | 6 | Channel 2 feedback A count |
| ch2_b_cnt_o | output | 12 | Channel 2 feedback B count |
| ch2_fb_aux_o | output | 4 | Channel 2 feedback auxiliary field |

## Verification
The default synchronizer has two stages, so a serial-clock or strobe rising edge acts on the third system clock edge after the pin changes. The bench holds every serial level for at least four system clocks. It samples the outputs four clocks after raising the strobe and again four clocks after lowering it, so each check falls after the update is due and before any further stimulus. Data-line changes during the high phase come three clocks after the serial clock rises, which is after the bit has been captured. Reset results are read two clocks after `rst_n` returns high.

// File: rtl/pll_ser_pkg.sv
// Package: shared widths, routing codes and word layouts for the
// dual-synthesizer serial programming port.
// Assumes the payload of every routed word is exactly REF_AUX_W+REF_W
// (= FB_AUX_W+B_W+A_W) bits wide, sitting above the routing code.
package pll_ser_pkg;

    localparam int FRAME_W   = 24;
    localparam int CTRL_W    = 2;
    localparam int PAYLOAD_W = FRAME_W - CTRL_W;
    localparam int REF_W     = 14;
    localparam int REF_AUX_W = PAYLOAD_W - REF_W;
    localparam int A_W       = 6;
    localparam int B_W       = 12;
    localparam int FB_AUX_W  = PAYLOAD_W - A_W - B_W;
    localparam int NUM_CH    = 2;

    // Routing codes carried in the two lowest word bits.
    typedef enum logic [CTRL_W-1:0] {
        DEST_CH2_REF = 2'b00,
        DEST_CH2_FB  = 2'b01,
        DEST_CH1_REF = 2'b10,
        DEST_CH1_FB  = 2'b11
    } dest_e;

    // Reference word payload, MSB first.
    typedef struct packed {
        logic [REF_AUX_W-1:0] aux;
        logic [REF_W-1:0]     cnt;
    } ref_word_t;

    // Feedback word payload, MSB first.
    typedef struct packed {
        logic [FB_AUX_W-1:0] aux;
        logic [B_W-1:0]      b;
        logic [A_W-1:0]      a;
    } fb_word_t;

endpackage

// File: rtl/pll_ser_sync.sv
// Module: multi-bit level synchronizer.
// Each bit passes through STAGES flops into the clk domain. Bits are
// treated independently; the caller keeps related inputs stable long
// enough that equal latency on every bit keeps them aligned.
module pll_ser_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe_q [STAGES];

    // Shift each input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/pll_ser_rise.sv
// Module: rising-edge detector for synchronized levels.
// Produces a one-cycle pulse on each bit whose level goes from 0 to 1.
// Assumes the input already belongs to the clk domain.
module pll_ser_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_q;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/pll_ser_shift.sv
// Module: serial-in shift register, MSB first.
// Each shift_en pulse moves the word up one place and puts bit_i in
// bit 0, so after FRAME_W pulses the first bit sent is the MSB.
module pll_ser_shift
    import pll_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);

    // Accept one serial bit per shift strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_o <= '0;
        else if (shift_en) frame_o <= {frame_o[FRAME_W-2:0], bit_i};
    end

endmodule

// File: rtl/pll_ser_bank.sv
// Module: four holding registers and routing decode.
// On load_en the payload of frame_i goes to the register named by its
// routing code. Index 0 is channel 1 and index 1 is channel 2.
// Assumes load_en is a single-cycle pulse.
module pll_ser_bank
    import pll_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] frame_i,
    output ref_word_t          ref_o [NUM_CH],
    output fb_word_t           fb_o  [NUM_CH]
);

    dest_e dest;
    assign dest = dest_e'(frame_i[CTRL_W-1:0]);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam dest_e REF_CODE = (ch == 0) ? DEST_CH1_REF : DEST_CH2_REF;
        localparam dest_e FB_CODE  = (ch == 0) ? DEST_CH1_FB  : DEST_CH2_FB;

        // Reference-divider holding register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ref_o[ch] <= '0;
            else if (load_en && dest == REF_CODE)
                ref_o[ch] <= ref_word_t'(frame_i[FRAME_W-1:CTRL_W]);
        end

        // Feedback-divider holding register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fb_o[ch] <= '0;
            else if (load_en && dest == FB_CODE)
                fb_o[ch] <= fb_word_t'(frame_i[FRAME_W-1:CTRL_W]);
        end
    end

endmodule

// File: rtl/pll_ser_load.sv
// Module: dual-synthesizer serial programming port (top).
// Synchronizes the three serial pins, detects serial-clock and strobe
// rising edges, shifts data MSB first and routes each word to one of
// four holding registers. Assumes each serial level lasts at least
// SYNC_STAGES+2 clk cycles.
module pll_ser_load
    import pll_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk_i,
    input  logic                 ser_data_i,
    input  logic                 ser_load_i,
    output logic [REF_W-1:0]     ch1_ref_cnt_o,
    output logic [REF_AUX_W-1:0] ch1_ref_aux_o,
    output logic [A_W-1:0]       ch1_a_cnt_o,
    output logic [B_W-1:0]       ch1_b_cnt_o,
    output logic [FB_AUX_W-1:0]  ch1_fb_aux_o,
    output logic [REF_W-1:0]     ch2_ref_cnt_o,
    output logic [REF_AUX_W-1:0] ch2_ref_aux_o,
    output logic [A_W-1:0]       ch2_a_cnt_o,
    output logic [B_W-1:0]       ch2_b_cnt_o,
    output logic [FB_AUX_W-1:0]  ch2_fb_aux_o
);

    logic [2:0]         pin_lvl;
    logic [1:0]         rises;
    logic               shift_stb;
    logic               load_stb;
    logic               data_bit;
    logic [FRAME_W-1:0] shift_q;
    ref_word_t          ref_w [NUM_CH];
    fb_word_t           fb_w  [NUM_CH];

    pll_ser_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_clk_i, ser_data_i, ser_load_i}),
        .q_o   (pin_lvl)
    );

    pll_ser_rise #(.W(2)) i_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({pin_lvl[2], pin_lvl[0]}),
        .rise_o  (rises)
    );

    assign shift_stb = rises[1];
    assign load_stb  = rises[0];
    assign data_bit  = pin_lvl[1];

    pll_ser_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_stb),
        .bit_i    (data_bit),
        .frame_o  (shift_q)
    );

    pll_ser_bank i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_stb),
        .frame_i (shift_q),
        .ref_o   (ref_w),
        .fb_o    (fb_w)
    );

    assign ch1_ref_cnt_o = ref_w[0].cnt;
    assign ch1_ref_aux_o = ref_w[0].aux;
    assign ch1_a_cnt_o   = fb_w[0].a;
    assign ch1_b_cnt_o   = fb_w[0].b;
    assign ch1_fb_aux_o  = fb_w[0].aux;
    assign ch2_ref_cnt_o = ref_w[1].cnt;
    assign ch2_ref_aux_o = ref_w[1].aux;
    assign ch2_a_cnt_o   = fb_w[1].a;
    assign ch2_b_cnt_o   = fb_w[1].b;
    assign ch2_fb_aux_o  = fb_w[1].aux;

endmodule

// File: rtl/pll_ser_load_chk.sv
// Module: assertion checker for pll_ser_load, attached by bind.
// Relates the edge strobes and the shift register to the output ports.
module pll_ser_load_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        shift_stb,
    input logic        load_stb,
    input logic        data_bit,
    input logic [23:0] shift_q,
    input logic [13:0] ch1_ref_cnt_o,
    input logic [7:0]  ch1_ref_aux_o,
    input logic [5:0]  ch1_a_cnt_o,
    input logic [11:0] ch1_b_cnt_o,
    input logic [3:0]  ch1_fb_aux_o,
    input logic [13:0] ch2_ref_cnt_o,
    input logic [7:0]  ch2_ref_aux_o,
    input logic [5:0]  ch2_a_cnt_o,
    input logic [11:0] ch2_b_cnt_o,
    input logic [3:0]  ch2_fb_aux_o
);

    logic [21:0] c1_ref, c1_fb, c2_ref, c2_fb;
    assign c1_ref = {ch1_ref_aux_o, ch1_ref_cnt_o};
    assign c1_fb  = {ch1_fb_aux_o, ch1_b_cnt_o, ch1_a_cnt_o};
    assign c2_ref = {ch2_ref_aux_o, ch2_ref_cnt_o};
    assign c2_fb  = {ch2_fb_aux_o, ch2_b_cnt_o, ch2_a_cnt_o};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (c1_ref == '0 && c1_fb == '0 && c2_ref == '0 && c2_fb == '0));

    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> shift_q == {$past(shift_q[22:0]), $past(data_bit)});

    p_ch2_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && shift_q[1:0] == 2'b00) |=> c2_ref == $past(shift_q[23:2]));

    p_ch2_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && shift_q[1:0] == 2'b01) |=> c2_fb == $past(shift_q[23:2]));

    p_ch1_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && shift_q[1:0] == 2'b10) |=> c1_ref == $past(shift_q[23:2]));

    p_ch1_fb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && shift_q[1:0] == 2'b11) |=> c1_fb == $past(shift_q[23:2]));

    p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> $countones({!$stable(c1_ref), !$stable(c1_fb),
                                 !$stable(c2_ref), !$stable(c2_fb)}) <= 1);

    p_hold_without_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable({c1_ref, c1_fb, c2_ref, c2_fb}));

endmodule

bind pll_ser_load pll_ser_load_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_stb     (shift_stb),
    .load_stb      (load_stb),
    .data_bit      (data_bit),
    .shift_q       (shift_q),
    .ch1_ref_cnt_o (ch1_ref_cnt_o),
    .ch1_ref_aux_o (ch1_ref_aux_o),
    .ch1_a_cnt_o   (ch1_a_cnt_o),
    .ch1_b_cnt_o   (ch1_b_cnt_o),
    .ch1_fb_aux_o  (ch1_fb_aux_o),
    .ch2_ref_cnt_o (ch2_ref_cnt_o),
    .ch2_ref_aux_o (ch2_ref_aux_o),
    .ch2_a_cnt_o   (ch2_a_cnt_o),
    .ch2_b_cnt_o   (ch2_b_cnt_o),
    .ch2_fb_aux_o  (ch2_fb_aux_o)
);

// File: tb/test_pll_ser_load.sv
`timescale 1ns/1ps
// Bench: drives serial words into pll_ser_load and checks all output
// fields against an arithmetic model of the four holding registers.
module test_pll_ser_load;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;

    logic [13:0] ch1_ref_cnt, ch2_ref_cnt;
    logic [7:0]  ch1_ref_aux, ch2_ref_aux;
    logic [5:0]  ch1_a, ch2_a;
    logic [11:0] ch1_b, ch2_b;
    logic [3:0]  ch1_fbx, ch2_fbx;

    int checks = 0;
    int errors = 0;

    // Model: index 0 = channel 1, index 1 = channel 2.
    logic [13:0] m_ref_cnt [2];
    logic [7:0]  m_ref_aux [2];
    logic [5:0]  m_a       [2];
    logic [11:0] m_b       [2];
    logic [3:0]  m_fbx     [2];

    always #2.5 clk = ~clk;

    pll_ser_load i_pll_ser_load (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_clk_i     (ser_clk),
        .ser_data_i    (ser_data),
        .ser_load_i    (ser_load),
        .ch1_ref_cnt_o (ch1_ref_cnt),
        .ch1_ref_aux_o (ch1_ref_aux),
        .ch1_a_cnt_o   (ch1_a),
        .ch1_b_cnt_o   (ch1_b),
        .ch1_fb_aux_o  (ch1_fbx),
        .ch2_ref_cnt_o (ch2_ref_cnt),
        .ch2_ref_aux_o (ch2_ref_aux),
        .ch2_a_cnt_o   (ch2_a),
        .ch2_b_cnt_o   (ch2_b),
        .ch2_fb_aux_o  (ch2_fbx)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_ref_cnt[c] = '0; m_ref_aux[c] = '0;
            m_a[c] = '0; m_b[c] = '0; m_fbx[c] = '0;
        end
    endtask

    // Routing: bit1=1 -> channel 1, bit0=1 -> feedback register.
    task automatic model_apply(input logic [23:0] w);
        int c;
        c = w[1] ? 0 : 1;
        if (w[0]) begin
            m_a[c] = w[7:2]; m_b[c] = w[19:8]; m_fbx[c] = w[23:20];
        end else begin
            m_ref_cnt[c] = w[15:2]; m_ref_aux[c] = w[23:16];
        end
    endtask

    task automatic cmp(input string ctx, input string req, input string name,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s %s: got %0h expected %0h", ctx, req, name, got, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        cmp(ctx, "R5", "ch1_ref_cnt", 32'(ch1_ref_cnt), 32'(m_ref_cnt[0]));
        cmp(ctx, "R5", "ch1_ref_aux", 32'(ch1_ref_aux), 32'(m_ref_aux[0]));
        cmp(ctx, "R6", "ch1_a",       32'(ch1_a),       32'(m_a[0]));
        cmp(ctx, "R6", "ch1_b",       32'(ch1_b),       32'(m_b[0]));
        cmp(ctx, "R6", "ch1_fb_aux",  32'(ch1_fbx),     32'(m_fbx[0]));
        cmp(ctx, "R3", "ch2_ref_cnt", 32'(ch2_ref_cnt), 32'(m_ref_cnt[1]));
        cmp(ctx, "R3", "ch2_ref_aux", 32'(ch2_ref_aux), 32'(m_ref_aux[1]));
        cmp(ctx, "R4", "ch2_a",       32'(ch2_a),       32'(m_a[1]));
        cmp(ctx, "R4", "ch2_b",       32'(ch2_b),       32'(m_b[1]));
        cmp(ctx, "R4", "ch2_fb_aux",  32'(ch2_fbx),     32'(m_fbx[1]));
    endtask

    // Send n bits of v, MSB first; data glitches while the clock is
    // low before settling and flips during the high phase (R9).
    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = ~v[i];
            step(1);
            ser_data = v[i];
            step(4);
            ser_clk = 1'b1;
            step(3);
            ser_data = ~v[i];
            step(2);
            ser_clk = 1'b0;
        end
    endtask

    task automatic load_pulse();
        ser_load = 1'b1;
        step(4);
        ser_load = 1'b0;
        step(4);
    endtask

    task automatic send_and_load(input logic [23:0] w, input string ctx);
        shift_bits(32'(w), 24);
        load_pulse();
        model_apply(w);
        check_all(ctx);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] w;
        logic [21:0] pay;
        model_clear();
        step(4);
        rst_n = 1'b1;
        step(2);
        check_all("R1 reset");

        // R7 walking one over every payload bit for every routing code.
        for (int d = 0; d < 4; d++) begin
            for (int b = 0; b < 22; b++) begin
                pay = 22'(1) << b;
                send_and_load({pay, 2'(d)}, "R7 walk");
            end
        end

        // R7 arithmetic patterns across all routing codes.
        for (int k = 0; k < 16; k++) begin
            pay = 22'((k * 32'h2D1B7 + 32'h15A3C) ^ (k << 17));
            send_and_load({pay, 2'(k)}, "R7 pattern");
        end

        // R2: six leading bits are pushed out by the 24-bit word.
        shift_bits(32'h2D, 6);
        send_and_load(24'h9C_3A5F, "R2 overlength");

        // R8: strobe raised (reloads current word), then shift with it held.
        w = 24'h9C_3A5F;
        ser_load = 1'b1;
        step(6);
        model_apply(w);
        check_all("R8 strobe raised");
        shift_bits(32'h5B_E246, 24);
        step(4);
        check_all("R8 strobe held");
        ser_load = 1'b0;
        step(4);
        check_all("R8 strobe released");
        load_pulse();
        model_apply(24'h5B_E246);
        check_all("R8 after new edge");
        shift_bits(32'hA1_7C09, 24);
        step(4);
        check_all("R8 shift without strobe");

        // R9: alternating data with glitches between clock edges.
        send_and_load(24'hAA_AAAA, "R9 alternating");
        send_and_load(24'h55_5557, "R9 alternating inverse");

        // R1: reset in mid-operation clears registers and shift register.
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(2);
        model_clear();
        check_all("R1 mid reset");
        shift_bits(32'hFD, 8);
        load_pulse();
        model_apply(24'h0000FD);
        check_all("R1 shift cleared");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule